// File: doc/BRIEF.md
# USB Endpoint Stall and Status Controller

This block holds the per-endpoint state of a full-speed USB device controller: whether each endpoint is halted, which of its two packet buffers are occupied, the data toggle for its next packet, whether a control setup is pending or has been clobbered, and which buffer the local processor is working on. It serves sixteen slots. Slot 0 is control OUT, slot 1 is control IN, and slots 2 to 15 are endpoints 1 to 14.

A microcontroller drives a byte-wide command port to halt or release endpoints. It reads one status byte per endpoint through a read strobe and an index. The serial engine reports one-cycle event strobes: a SETUP token, completion of the setup data write, a packet accepted into a buffer, and a successful transaction. The processor reports buffer releases. The block also exports a vector of halt bits, which the serial engine uses to answer with STALL handshakes.

All pins are plain control and status pins. Commands and events are taken on any cycle in which they are strobed, so no back-pressure exists. The status byte is a combinational snapshot that is valid in the same cycle as its strobe.

Top module: `usb_ep_status_ctrl`

## Requirements
- R1: A command byte 0x40+n (n = 0..15) halts slot n on the next clock, and this is seen as stall_vec bit n and as status bit 7. Command bytes outside 0x40–0x4F and 0x80–0x8F change nothing.
- R2: A command byte 0x80+n clears the halt of slot n on the next clock.
- R3: A SETUP strobe clears the halt of slots 0 and 1 on the next clock, whatever their previous state.
- R4: Any change of a slot from halted to not halted, whether by command or by SETUP, clears both buffer-full flags, the CPU buffer bit and the data toggle (to DATA0). The setup flags are kept.
- R5: The status byte is laid out as follows: bit 7 halted, bit 6 secondary buffer full, bit 5 primary buffer full, bit 4 next data PID (0 = DATA0, 1 = DATA1), bit 3 setup overwritten, bit 2 setup present, bit 1 CPU buffer (0 = primary, 1 = secondary), bit 0 always 0. After reset every bit of every slot is 0.
- R6: A SETUP strobe sets the setup-present bit of slot 0. If that bit is already set, the SETUP strobe also sets the overwrite bit. A release of slot 0 clears the setup-present bit.
- R7: The status byte shows the state in the same cycle as the read strobe. The overwrite bit of the slot being read is cleared at the clock that ends the read, but only if a setup-write-done strobe has arrived since the last SETUP strobe. Otherwise the bit stays set.
- R8: A successful-transaction strobe toggles the data PID of a slot that is not halted and has no effect on a halted slot. A setup-write-done strobe sets the PID of slots 0 and 1 to DATA1.
- R9: A fill strobe marks the CPU-selected buffer as full if it is empty, otherwise the other buffer if that one is empty. A fill strobe is ignored on a halted slot. A release strobe clears the selected buffer's full flag and switches the CPU buffer bit when the other buffer is full.
- R10: When a command and a SETUP strobe arrive in the same cycle, the command is applied after the SETUP strobe. An explicit halt of slot 0 or slot 1 therefore takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| sie_setup | input | 1 | SETUP token received on the control pair |
| sie_setup_done | input | 1 | Setup data write finished |
| sie_ep | input | 4 | Slot index for fill and transaction strobes |
| sie_fill | input | 1 | Packet accepted into a buffer of slot sie_ep |
| sie_xact_ok | input | 1 | Successful data transaction on slot sie_ep |
| cpu_ep | input | 4 | Slot index for buffer release |
| cpu_release | input | 1 | CPU releases its selected buffer of slot cpu_ep |
| rd_req | input | 1 | Status read strobe |
| rd_ep | input | 4 | Slot index to read |
| rd_data | output | 8 | Status byte of slot rd_ep |
| stall_vec | output | 16 | Halt bit of every slot |

## Verification
The assertions assume several things about the inputs. Each strobe lasts one cycle. Indices are in range while their strobe is high. At most one command arrives per cycle. The halt properties rely only on cmd_valid, cmd_code and sie_setup, so they hold for any mix of fill, release and transaction events. The stimulus drives every strobe for exactly one clock from the falling edge. Status reads that must not clear the overwrite bit are raised and lowered between two rising edges, so no clock edge sees them.

// File: rtl/usb_eps_pkg.sv
package usb_eps_pkg;

  localparam int EPS_MAX_SLOTS = 16;

  typedef struct packed {
    logic stall;
    logic full1;
    logic full0;
    logic pid;
    logic ovw;
    logic setup;
    logic cpubuf;
  } ep_st_t;

  localparam ep_st_t EP_ST_RESET = '{default: 1'b0};

  localparam logic [3:0] OPC_STALL   = 4'h4;
  localparam logic [3:0] OPC_UNSTALL = 4'h8;

  function automatic logic [7:0] st_to_byte(input ep_st_t s);
    return {s, 1'b0};
  endfunction

endpackage

// File: rtl/usb_eps_cmd_dec.sv
module usb_eps_cmd_dec
  import usb_eps_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int CMD_W  = 8
) (
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic [NUM_EP-1:0] stall_hot,
  output logic [NUM_EP-1:0] unstall_hot
);
  localparam int OPC_LSB = CMD_W - 4;

  logic [3:0] opc;
  logic [3:0] idx;
  logic       is_stall;
  logic       is_unstall;

  assign opc        = cmd_code[CMD_W-1:OPC_LSB];
  assign idx        = cmd_code[3:0];
  assign is_stall   = cmd_valid && (opc == OPC_STALL);
  assign is_unstall = cmd_valid && (opc == OPC_UNSTALL);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_hot
    localparam logic [3:0] SLOT = 4'(g);
    assign stall_hot[g]   = is_stall   && (idx == SLOT);
    assign unstall_hot[g] = is_unstall && (idx == SLOT);
  end

endmodule

// File: rtl/usb_eps_slot.sv
module usb_eps_slot
  import usb_eps_pkg::*;
#(
  parameter bit IS_CTRL     = 1'b0,
  parameter bit IS_CTRL_OUT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_stall,
  input  logic       op_unstall,
  input  logic       ev_setup,
  input  logic       ev_setup_done,
  input  logic       ev_fill,
  input  logic       ev_release,
  input  logic       ev_xact,
  input  logic       rd_hit,
  input  logic       wr_busy,
  output ep_st_t     st_o,
  output logic [7:0] byte_o
);
  ep_st_t st_q;
  ep_st_t st_d;
  logic   halt_after;
  logic   sel_full;
  logic   oth_full;

  always_comb begin
    st_d     = st_q;
    sel_full = st_q.cpubuf ? st_q.full1 : st_q.full0;
    oth_full = st_q.cpubuf ? st_q.full0 : st_q.full1;

    // processor release of the selected buffer
    if (ev_release) begin
      if (st_q.cpubuf) st_d.full1 = 1'b0;
      else             st_d.full0 = 1'b0;
      if (oth_full)    st_d.cpubuf = ~st_q.cpubuf;
      if (IS_CTRL_OUT) st_d.setup = 1'b0;
    end

    // packet accepted into the selected buffer, else the other one
    if (ev_fill && !st_q.stall) begin
      if (!(st_d.cpubuf ? st_d.full1 : st_d.full0)) begin
        if (st_d.cpubuf) st_d.full1 = 1'b1;
        else             st_d.full0 = 1'b1;
      end else if (!(st_d.cpubuf ? st_d.full0 : st_d.full1)) begin
        if (st_d.cpubuf) st_d.full0 = 1'b1;
        else             st_d.full1 = 1'b1;
      end
    end

    if (ev_xact && !st_q.stall) st_d.pid = ~st_q.pid;
    if (IS_CTRL && ev_setup_done) st_d.pid = 1'b1;

    // read-side clear of the overwrite flag
    if (IS_CTRL_OUT && rd_hit && !wr_busy) st_d.ovw = 1'b0;

    // SETUP token: releases the halt of the control pair
    if (IS_CTRL && ev_setup) begin
      st_d.stall = 1'b0;
      if (IS_CTRL_OUT) begin
        if (st_q.setup) st_d.ovw = 1'b1;
        st_d.setup = 1'b1;
      end
    end

    // explicit commands are applied last
    if (op_stall)   st_d.stall = 1'b1;
    if (op_unstall) st_d.stall = 1'b0;

    halt_after = st_d.stall;
    if (st_q.stall && !halt_after) begin
      st_d.full0  = 1'b0;
      st_d.full1  = 1'b0;
      st_d.pid    = 1'b0;
      st_d.cpubuf = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= EP_ST_RESET;
    else        st_q <= st_d;
  end

  assign st_o   = st_q;
  assign byte_o = st_to_byte(st_q);

endmodule

// File: rtl/usb_eps_rd_mux.sv
module usb_eps_rd_mux #(
  parameter int NUM_EP = 16,
  parameter int IDX_W  = 4
) (
  input  logic [NUM_EP-1:0][7:0] bytes_i,
  input  logic                   rd_req,
  input  logic [IDX_W-1:0]       rd_ep,
  output logic [7:0]             rd_data
);
  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_EP; k++) begin
      if (rd_req && (rd_ep == IDX_W'(k))) rd_data = bytes_i[k];
    end
  end
endmodule

// File: rtl/usb_ep_status_ctrl.sv
module usb_ep_status_ctrl
  import usb_eps_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int CMD_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              sie_setup,
  input  logic              sie_setup_done,
  input  logic [IDX_W-1:0]  sie_ep,
  input  logic              sie_fill,
  input  logic              sie_xact_ok,
  input  logic [IDX_W-1:0]  cpu_ep,
  input  logic              cpu_release,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_ep,
  output logic [7:0]        rd_data,
  output logic [NUM_EP-1:0] stall_vec
);
  logic [NUM_EP-1:0]      stall_hot;
  logic [NUM_EP-1:0]      unstall_hot;
  logic [NUM_EP-1:0][7:0] slot_bytes;
  ep_st_t                 slot_st [NUM_EP];
  logic                   setup_busy_q;

  usb_eps_cmd_dec #(.NUM_EP(NUM_EP), .CMD_W(CMD_W)) i_dec (
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .stall_hot  (stall_hot),
    .unstall_hot(unstall_hot)
  );

  // setup data write in flight: from SETUP until write-done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              setup_busy_q <= 1'b0;
    else if (sie_setup)      setup_busy_q <= 1'b1;
    else if (sie_setup_done) setup_busy_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    usb_eps_slot #(
      .IS_CTRL    (g < 2),
      .IS_CTRL_OUT(g == 0)
    ) i_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_stall     (stall_hot[g]),
      .op_unstall   (unstall_hot[g]),
      .ev_setup     (sie_setup),
      .ev_setup_done(sie_setup_done),
      .ev_fill      (sie_fill && (sie_ep == SLOT)),
      .ev_release   (cpu_release && (cpu_ep == SLOT)),
      .ev_xact      (sie_xact_ok && (sie_ep == SLOT)),
      .rd_hit       (rd_req && (rd_ep == SLOT)),
      .wr_busy      (setup_busy_q),
      .st_o         (slot_st[g]),
      .byte_o       (slot_bytes[g])
    );
    assign stall_vec[g] = slot_st[g].stall;
  end

  usb_eps_rd_mux #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) i_mux (
    .bytes_i(slot_bytes),
    .rd_req (rd_req),
    .rd_ep  (rd_ep),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/usb_ep_status_ctrl_chk.sv
module usb_ep_status_ctrl_chk #(
  parameter int NUM_EP = 16,
  parameter int CMD_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_code,
  input logic              sie_setup,
  input logic              rd_req,
  input logic [7:0]        rd_data,
  input logic [NUM_EP-1:0] stall_vec
);
  logic is_stall_cmd;
  logic is_unstall_cmd;
  logic ctrl_stall_cmd;

  assign is_stall_cmd   = cmd_valid && (cmd_code[CMD_W-1:CMD_W-4] == 4'h4);
  assign is_unstall_cmd = cmd_valid && (cmd_code[CMD_W-1:CMD_W-4] == 4'h8);
  assign ctrl_stall_cmd = is_stall_cmd && (cmd_code[3:1] == 3'b000);

  AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    is_stall_cmd |=> stall_vec[$past(cmd_code[3:0])]); // R1

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !sie_setup) |=> $stable(stall_vec)); // R1

  AST_UNSTALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    is_unstall_cmd |=> !stall_vec[$past(cmd_code[3:0])]); // R2

  AST_SETUP_UNSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_setup && !ctrl_stall_cmd) |=> (stall_vec[1:0] == 2'b00)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_data[0] == 1'b0)); // R5

  AST_CMD_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_setup && cmd_valid && (cmd_code == 8'h40)) |=> stall_vec[0]); // R10

endmodule

bind usb_ep_status_ctrl usb_ep_status_ctrl_chk #(
  .NUM_EP(NUM_EP),
  .CMD_W (CMD_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_code (cmd_code),
  .sie_setup(sie_setup),
  .rd_req   (rd_req),
  .rd_data  (rd_data),
  .stall_vec(stall_vec)
);

// File: tb/test_usb_ep_status_ctrl.sv
`timescale 1ns/1ps
module test_usb_ep_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        sie_setup = 1'b0;
  logic        sie_setup_done = 1'b0;
  logic [3:0]  sie_ep = 4'h0;
  logic        sie_fill = 1'b0;
  logic        sie_xact_ok = 1'b0;
  logic [3:0]  cpu_ep = 4'h0;
  logic        cpu_release = 1'b0;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_ep = 4'h0;
  logic [7:0]  rd_data;
  logic [15:0] stall_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_ep_status_ctrl i_usb_ep_status_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sie_setup(sie_setup), .sie_setup_done(sie_setup_done), .sie_ep(sie_ep),
    .sie_fill(sie_fill), .sie_xact_ok(sie_xact_ok), .cpu_ep(cpu_ep),
    .cpu_release(cpu_release), .rd_req(rd_req), .rd_ep(rd_ep),
    .rd_data(rd_data), .stall_vec(stall_vec)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  // read with no clock edge in the strobe: no side effect
  task automatic peek(input logic [3:0] k, output logic [7:0] v);
    rd_ep = k; rd_req = 1'b1; #1 v = rd_data; rd_req = 1'b0; #1;
  endtask

  // read held across one rising edge
  task automatic rd_clr(input logic [3:0] k, output logic [7:0] v);
    @(negedge clk); rd_ep = k; rd_req = 1'b1; #1 v = rd_data;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic fill(input logic [3:0] k);
    @(negedge clk); sie_ep = k; sie_fill = 1'b1;
    @(negedge clk); sie_fill = 1'b0;
  endtask

  task automatic xact(input logic [3:0] k);
    @(negedge clk); sie_ep = k; sie_xact_ok = 1'b1;
    @(negedge clk); sie_xact_ok = 1'b0;
  endtask

  task automatic rel(input logic [3:0] k);
    @(negedge clk); cpu_ep = k; cpu_release = 1'b1;
    @(negedge clk); cpu_release = 1'b0;
  endtask

  task automatic setup_tok();
    @(negedge clk); sie_setup = 1'b1;
    @(negedge clk); sie_setup = 1'b0;
  endtask

  task automatic setup_done();
    @(negedge clk); sie_setup_done = 1'b1;
    @(negedge clk); sie_setup_done = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: reset state of every slot
    chk("R5 reset stall_vec", stall_vec, 16'h0000);
    for (int k = 0; k < 16; k++) begin
      peek(4'(k), v);
      chk("R5 reset status", {8'h00, v}, 16'h0000);
    end

    // R1 / R2: halt and release every slot
    for (int k = 0; k < 16; k++) begin
      cmd(8'h40 | 8'(k));
      chk("R1 stall_vec", stall_vec, 16'(1) << k);
      peek(4'(k), v);
      chk("R1 status bit7", {8'h00, v}, 16'h0080);
      cmd(8'h80 | 8'(k));
      chk("R2 stall_vec", stall_vec, 16'h0000);
    end

    // R1: every other command code leaves the halt bits alone
    for (int c = 0; c < 256; c++) begin
      if ((c >> 4) != 4 && (c >> 4) != 8) begin
        cmd(8'(c));
        chk("R1 foreign code", stall_vec, 16'h0000);
      end
    end

    // R9: double buffering on slot 5
    fill(4'd5);  peek(4'd5, v); chk("R9 fill primary", {8'h00, v}, 16'h0020);
    fill(4'd5);  peek(4'd5, v); chk("R9 fill secondary", {8'h00, v}, 16'h0060);
    fill(4'd5);  peek(4'd5, v); chk("R9 fill both full", {8'h00, v}, 16'h0060);
    rel(4'd5);   peek(4'd5, v); chk("R9 release swaps", {8'h00, v}, 16'h0042);
    rel(4'd5);   peek(4'd5, v); chk("R9 release no swap", {8'h00, v}, 16'h0002);
    fill(4'd5);  peek(4'd5, v); chk("R9 fill selected", {8'h00, v}, 16'h0042);

    // R8: PID toggle on slot 3, frozen while halted
    xact(4'd3);  peek(4'd3, v); chk("R8 toggle to DATA1", {8'h00, v}, 16'h0010);
    xact(4'd3);  peek(4'd3, v); chk("R8 toggle to DATA0", {8'h00, v}, 16'h0000);
    xact(4'd3);
    cmd(8'h43);
    xact(4'd3);  peek(4'd3, v); chk("R8 halted no toggle", {8'h00, v}, 16'h0090);

    // R4: release of a halt reinitializes the slot
    cmd(8'h83);  peek(4'd3, v); chk("R4 reinit slot3", {8'h00, v}, 16'h0000);
    xact(4'd5);  peek(4'd5, v); chk("R8 slot5 toggle", {8'h00, v}, 16'h0052);
    cmd(8'h45);
    fill(4'd5);  peek(4'd5, v); chk("R9 fill ignored when halted", {8'h00, v}, 16'h00D2);
    cmd(8'h85);  peek(4'd5, v); chk("R4 reinit slot5", {8'h00, v}, 16'h0000);

    // R3 / R6 / R4 / R8: SETUP on a halted control pair
    cmd(8'h40);
    cmd(8'h41);
    chk("R3 pre-setup halts", stall_vec, 16'h0003);
    setup_tok();
    chk("R3 setup unstalls", stall_vec, 16'h0000);
    peek(4'd0, v); chk("R6 setup present", {8'h00, v}, 16'h0004);
    peek(4'd1, v); chk("R4 ctrl IN reinit", {8'h00, v}, 16'h0000);
    setup_done();
    peek(4'd0, v); chk("R8 ctrl OUT DATA1", {8'h00, v}, 16'h0014);
    peek(4'd1, v); chk("R8 ctrl IN DATA1", {8'h00, v}, 16'h0010);

    // R6 / R7: overwrite and read-clear
    setup_tok();
    peek(4'd0, v); chk("R6 overwrite set", {8'h00, v}, 16'h001C);
    rd_clr(4'd0, v); chk("R7 snapshot", {8'h00, v}, 16'h001C);
    peek(4'd0, v); chk("R7 no clear while busy", {8'h00, v}, 16'h001C);
    setup_done();
    rd_clr(4'd0, v); chk("R7 snapshot before clear", {8'h00, v}, 16'h001C);
    peek(4'd0, v); chk("R7 cleared after write", {8'h00, v}, 16'h0014);
    rel(4'd0);
    peek(4'd0, v); chk("R6 release clears setup", {8'h00, v}, 16'h0010);

    // R10: halt command in the same cycle as SETUP
    @(negedge clk); sie_setup = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h40;
    @(negedge clk); sie_setup = 1'b0; cmd_valid = 1'b0;
    chk("R10 stall wins", stall_vec, 16'h0001);
    peek(4'd0, v); chk("R10 status", {8'h00, v}, 16'h0094);
    cmd(8'h80);
    peek(4'd0, v); chk("R4 setup kept on reinit", {8'h00, v}, 16'h0004);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule